// File: doc/BRIEF.md
# Real-Mode Split Word Access Unit

This unit sits between a 16-bit real-mode execution core and a 1 MiB byte-addressed memory. The core asks for a byte or a 16-bit word, sending a linear address, the base of the current segment and an access kind. Most accesses go to memory unchanged. A word that would run past the top of physical memory, or past the last byte of a 64 KiB segment, is split into two byte cycles. In that case the high byte wraps to physical address 0, or to the segment base.

A split read comes back as one assembled word. A split write or read-modify-write does not update memory when it is requested. The unit records the two byte addresses, seeding the held value from memory for a read-modify-write, and then waits. A later write-back strobe carries the final word, and only then are both bytes stored. While that write-back is outstanding, new requests are not acknowledged. An input selects whether segment-end wrapping applies or only the physical-end wrap does.

Top module: `rm_split_access`

## Requirements
- R1: The request address is reduced modulo 2^20 before any decoding or memory access, so bits above bit 19 have no effect.
- R2: A byte access (req_word_i=0) is never split. It makes one memory cycle at the reduced address, with `ack_o` high in the cycle that starts 2 clock edges after the accepting edge. A byte read returns {8'h00, byte}.
- R3: A word that straddles no boundary makes one word-wide memory cycle at the reduced address, little-endian (low byte at the address). `ack_o` is high in the cycle that starts 2 edges after acceptance, for one cycle only.
- R4: A word whose reduced address is 0xFFFFF is split: the low byte is at 0xFFFFF and the high byte at 0x00000. This rule takes precedence over the segment rule.
- R5: With seg_wrap_i=1, a word whose reduced address equals base+0xFFFF (sum taken without 20-bit wrap) is split: the low byte is at the address and the high byte at the base. With seg_wrap_i=0 this split does not occur.
- R6: A split read (kind 0 or 3) returns {high byte from the wrap target, low byte}. `ack_o` is high in the cycle that starts 3 edges after acceptance.
- R7: A split read-modify-write (kind 2) makes two byte reads, returns the assembled seed word with `ack_o` 3 edges after acceptance, and leaves a write-back pending. Memory is not written.
- R8: A split write (kind 1) makes no memory cycle. It acknowledges 1 edge after acceptance and leaves a write-back pending.
- R9: A write-back strobe (wb_i) while a write-back is pending stores wb_data_i[7:0] at the low address and wb_data_i[15:8] at the wrap target, in two byte cycles. `ack_o` is high 3 edges after the strobe is taken, and nothing is pending afterwards.
- R10: A write-back strobe with nothing pending causes no memory cycle and no `ack_o`.
- R11: While a write-back is pending, a request is neither acknowledged nor given any memory cycle.
- R12: An unsplit write stores the data directly in its one cycle. An unsplit read-modify-write is only a read and leaves nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_wrap_i | input | 1 | Enables segment-end splitting |
| req_i | input | 1 | Request, held until `ack_o` |
| req_word_i | input | 1 | 1 selects a word, 0 selects a byte |
| req_kind_i | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr_i | input | IN_AW (24) | Linear address |
| req_base_i | input | AW (20) | Segment base |
| req_wdata_i | input | 16 | Write data for unsplit writes (byte in [7:0]) |
| wb_i | input | 1 | Write-back strobe, one cycle |
| wb_data_i | input | 16 | Final word for a pending write-back |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with `ack_o` |
| mem_en_o | output | 1 | Memory cycle enable |
| mem_we_o | output | 1 | Memory write |
| mem_word_o | output | 1 | Word-wide cycle (bytes at addr and addr+1) |
| mem_addr_o | output | AW (20) | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid in the same cycle as the address |

## Verification
A request is taken at the first rising edge after it is driven. `ack_o` then rises after a fixed number of edges: 2 for a byte or unsplit word, 3 for a split read or read-modify-write, 1 for a split write, and 3 for a write-back. The bench drives on falling edges, counts rising edges up to the falling edge where `ack_o` is first seen, and compares that count and `rdata_o` with values it derives from the boundary rules. Ignored strobes and refused requests are checked at the same falling-edge points, over a fixed window, by counting memory cycles and acknowledgements.

// File: rtl/swa_pkg.sv
package swa_pkg;
  typedef enum logic [1:0] {
    K_RD  = 2'd0,
    K_WR  = 2'd1,
    K_RMW = 2'd2,
    K_RD2 = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ONE,
    ST_LO,
    ST_HI,
    ST_WLO,
    ST_WHI,
    ST_ACK
  } st_e;
endpackage

// File: rtl/swa_decode.sv
module swa_decode #(
  parameter int IN_AW = 24,
  parameter int AW    = 20,
  parameter int SEG_W = 16
) (
  input  logic [IN_AW-1:0] addr_i,
  input  logic [AW-1:0]    base_i,
  input  logic             word_i,
  input  logic             seg_wrap_i,
  output logic [AW-1:0]    lo_o,
  output logic [AW-1:0]    hi_o,
  output logic             split_o
);
  localparam logic [AW:0] SEG_LAST = (AW+1)'((1 << SEG_W) - 1);

  logic [AW-1:0] maddr;
  logic [AW:0]   seg_end;
  logic          phys_hit;
  logic          seg_hit;

  assign maddr    = AW'(addr_i);
  assign seg_end  = {1'b0, base_i} + SEG_LAST;
  assign phys_hit = word_i && (maddr == {AW{1'b1}});
  assign seg_hit  = word_i && seg_wrap_i && ({1'b0, maddr} == seg_end);

  assign lo_o    = maddr;
  assign split_o = phys_hit || seg_hit;

  // physical wrap wins over segment wrap
  always_comb begin
    if (phys_hit)     hi_o = '0;
    else if (seg_hit) hi_o = base_i;
    else              hi_o = maddr + AW'(1);
  end
endmodule

// File: rtl/swa_hold.sv
module swa_hold #(
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic [15:0]   data_i,
  output logic          pending_o,
  output logic [AW-1:0] lo_o,
  output logic [AW-1:0] hi_o,
  output logic [15:0]   val_o
);
  logic [AW-1:0] lo_q, hi_q;
  logic [15:0]   val_q;

  // low address 0 never needs a split, so it marks "nothing pending"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      val_q <= '0;
    end else begin
      if (set_i) begin
        lo_q <= lo_i;
        hi_q <= hi_i;
      end else if (clr_i) begin
        lo_q <= '0;
      end
      if (cap_i) val_q <= data_i;
    end
  end

  assign pending_o = (lo_q != '0);
  assign lo_o      = lo_q;
  assign hi_o      = hi_q;
  assign val_o     = val_q;

  // R8
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pending_o);
  // R9
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pending_o);
endmodule

// File: rtl/rm_split_access.sv
module rm_split_access
  import swa_pkg::*;
#(
  parameter int IN_AW = 24,
  parameter int AW    = 20,
  parameter int SEG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg_wrap_i,
  input  logic             req_i,
  input  logic             req_word_i,
  input  logic [1:0]       req_kind_i,
  input  logic [IN_AW-1:0] req_addr_i,
  input  logic [AW-1:0]    req_base_i,
  input  logic [15:0]      req_wdata_i,
  input  logic             wb_i,
  input  logic [15:0]      wb_data_i,
  output logic             ack_o,
  output logic [15:0]      rdata_o,
  output logic             mem_en_o,
  output logic             mem_we_o,
  output logic             mem_word_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [15:0]      mem_wdata_o,
  input  logic [15:0]      mem_rdata_i
);
  st_e           st_q, st_d;
  logic [AW-1:0] dec_lo, dec_hi;
  logic          dec_split;
  logic [AW-1:0] lo_q, hi_q;
  logic          word_q;
  kind_e         kind_q;
  logic [15:0]   wdata_q, rdata_q;
  logic          pend;
  logic [AW-1:0] pend_lo, pend_hi;
  logic [15:0]   pend_val;
  logic          accept, take_wb, hold_set;
  kind_e         req_kind;

  assign req_kind = kind_e'(req_kind_i);

  swa_decode #(.IN_AW(IN_AW), .AW(AW), .SEG_W(SEG_W)) u_decode (
    .addr_i     (req_addr_i),
    .base_i     (req_base_i),
    .word_i     (req_word_i),
    .seg_wrap_i (seg_wrap_i),
    .lo_o       (dec_lo),
    .hi_o       (dec_hi),
    .split_o    (dec_split)
  );

  assign take_wb  = (st_q == ST_IDLE) && pend && wb_i;
  assign accept   = (st_q == ST_IDLE) && !pend && req_i;
  assign hold_set = accept && dec_split && (req_kind == K_WR || req_kind == K_RMW);

  swa_hold #(.AW(AW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (hold_set),
    .lo_i      (dec_lo),
    .hi_i      (dec_hi),
    .clr_i     (st_q == ST_WHI),
    .cap_i     (take_wb),
    .data_i    (wb_data_i),
    .pending_o (pend),
    .lo_o      (pend_lo),
    .hi_o      (pend_hi),
    .val_o     (pend_val)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (take_wb) st_d = ST_WLO;
        else if (accept) begin
          if (!dec_split)            st_d = ST_ONE;
          else if (req_kind == K_WR) st_d = ST_ACK;
          else                       st_d = ST_LO;
        end
      end
      ST_ONE:  st_d = ST_ACK;
      ST_LO:   st_d = ST_HI;
      ST_HI:   st_d = ST_ACK;
      ST_WLO:  st_d = ST_WHI;
      ST_WHI:  st_d = ST_ACK;
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      word_q  <= 1'b0;
      kind_q  <= K_RD;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        lo_q    <= dec_lo;
        hi_q    <= dec_hi;
        word_q  <= req_word_i;
        kind_q  <= req_kind;
        wdata_q <= req_wdata_i;
        rdata_q <= '0;
      end
      unique case (st_q)
        ST_ONE:  rdata_q <= word_q ? mem_rdata_i : {8'h00, mem_rdata_i[7:0]};
        ST_LO:   rdata_q[7:0]  <= mem_rdata_i[7:0];
        ST_HI:   rdata_q[15:8] <= mem_rdata_i[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_word_o  = 1'b0;
    mem_addr_o  = lo_q;
    mem_wdata_o = wdata_q;
    unique case (st_q)
      ST_ONE: begin
        mem_en_o   = 1'b1;
        mem_word_o = word_q;
        mem_we_o   = (kind_q == K_WR);
      end
      ST_LO:  mem_en_o = 1'b1;
      ST_HI: begin
        mem_en_o   = 1'b1;
        mem_addr_o = hi_q;
      end
      ST_WLO: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pend_lo;
        mem_wdata_o = {8'h00, pend_val[7:0]};
      end
      ST_WHI: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = pend_hi;
        mem_wdata_o = {8'h00, pend_val[15:8]};
      end
      default: ;
    endcase
  end

  assign ack_o   = (st_q == ST_ACK);
  assign rdata_o = rdata_q;

  // R3
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R3
  word_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && mem_word_o) |-> (mem_addr_o != {AW{1'b1}}));
  // R4
  phys_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HI && lo_q == {AW{1'b1}}) |-> (mem_addr_o == '0));
  // R11
  refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && pend && req_i && !wb_i) |=> (!mem_en_o && !ack_o));
  // R10
  wb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !pend && wb_i && !req_i) |=> (!mem_en_o && !ack_o));
endmodule

// File: tb/rm_split_access_bench.sv
module rm_split_access_bench;
  localparam int IN_AW = 24;
  localparam int AW    = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             seg_wrap = 1'b0;
  logic             req = 1'b0;
  logic             req_word = 1'b0;
  logic [1:0]       req_kind = 2'd0;
  logic [IN_AW-1:0] req_addr = '0;
  logic [AW-1:0]    req_base = '0;
  logic [15:0]      req_wdata = '0;
  logic             wb = 1'b0;
  logic [15:0]      wb_data = '0;
  logic             ack;
  logic [15:0]      rdata;
  logic             mem_en, mem_we, mem_word;
  logic [AW-1:0]    mem_addr;
  logic [15:0]      mem_wdata;
  logic [15:0]      mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int en_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rm_split_access #(.IN_AW(IN_AW), .AW(AW)) u_rm_split_access (
    .clk_i(clk), .rst_ni(rst_n), .seg_wrap_i(seg_wrap), .req_i(req),
    .req_word_i(req_word), .req_kind_i(req_kind), .req_addr_i(req_addr),
    .req_base_i(req_base), .req_wdata_i(req_wdata), .wb_i(wb),
    .wb_data_i(wb_data), .ack_o(ack), .rdata_o(rdata), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_word_o(mem_word), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // sparse memory model; unwritten bytes follow a fixed pattern
  logic [7:0] mem [int];

  function automatic logic [7:0] pat(input int a);
    logic [19:0] x;
    x = a[19:0];
    return x[7:0] ^ x[15:8] ^ {4'h0, x[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd8(input int a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction

  always @(negedge clk) begin
    mem_rdata <= {rd8(int'(mem_addr + 20'd1)), rd8(int'(mem_addr))};
  end

  always @(posedge clk) begin
    if (rst_n && mem_en) begin
      en_cnt <= en_cnt + 1;
      if (mem_we) begin
        mem[int'(mem_addr)] = mem_wdata[7:0];
        if (mem_word) mem[int'(mem_addr + 20'd1)] = mem_wdata[15:8];
      end
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input logic [1:0] k, input logic [IN_AW-1:0] a,
                        input logic [AW-1:0] b, input bit s, input logic [15:0] d,
                        output logic [15:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; req_word = w; req_kind = k; req_addr = a;
    req_base = b; seg_wrap = s; req_wdata = d;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (ack) break;
    end
    if (!ack) lat = 99;
    rd = rdata;
    req = 1'b0;
  endtask

  task automatic do_wb(input logic [15:0] d, output int lat);
    @(negedge clk);
    wb = 1'b1; wb_data = d;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      wb = 1'b0;
      lat++;
      if (ack) break;
    end
    if (!ack) lat = 99;
  endtask

  // idle window: counts acks and memory cycles over n cycles
  task automatic watch(input int n, output int acks, output int ens);
    int e0;
    e0 = en_cnt;
    acks = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (ack) acks++;
    end
    ens = en_cnt - e0;
  endtask

  typedef struct packed {
    logic             word;
    logic             seg;
    logic [IN_AW-1:0] addr;
    logic [AW-1:0]    base;
    logic [AW-1:0]    lo;
    logic [AW-1:0]    hi;
    logic [3:0]       lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 24'h012344, 20'h12000, 20'h12344, 20'h12345, 4'd2}, // R3
    '{1'b1, 1'b1, 24'h0FFFFF, 20'hF0000, 20'hFFFFF, 20'h00000, 4'd3}, // R4 over R5
    '{1'b1, 1'b1, 24'h01FFFF, 20'h10000, 20'h1FFFF, 20'h10000, 4'd3}, // R5
    '{1'b1, 1'b0, 24'h01FFFF, 20'h10000, 20'h1FFFF, 20'h20000, 4'd2}, // R5 off
    '{1'b1, 1'b0, 24'h1FFFFF, 20'h00000, 20'hFFFFF, 20'h00000, 4'd3}, // R1 R4
    '{1'b1, 1'b1, 24'h100010, 20'h00000, 20'h00010, 20'h00011, 4'd2}, // R1
    '{1'b0, 1'b1, 24'h0FFFFF, 20'hF0000, 20'hFFFFF, 20'h00000, 4'd2}, // R2
    '{1'b0, 1'b1, 24'h01FFFF, 20'h10000, 20'h1FFFF, 20'h00000, 4'd2}, // R2
    '{1'b1, 1'b1, 24'h02FFFE, 20'h20000, 20'h2FFFE, 20'h2FFFF, 4'd2}  // R3
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] exp;
    int lat, acks, ens, e0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ack == 1'b0 && mem_en == 1'b0, "R3 reset", {ack, mem_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: reads through all boundary rules (R1 R2 R3 R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      do_req(TBL[v].word, 2'd0, TBL[v].addr, TBL[v].base, TBL[v].seg, 16'h0, rd, lat);
      exp = TBL[v].word ? {rd8(int'(TBL[v].hi)), rd8(int'(TBL[v].lo))}
                        : {8'h00, rd8(int'(TBL[v].lo))};
      chk(rd == exp, $sformatf("R6 data vec%0d", v), rd, exp);
      chk(lat == int'(TBL[v].lat), $sformatf("R6 latency vec%0d", v), lat, TBL[v].lat);
    end

    // R10: strobe with nothing pending
    e0 = en_cnt;
    @(negedge clk); wb = 1'b1; wb_data = 16'hDEAD;
    @(negedge clk); wb = 1'b0;
    watch(4, acks, ens);
    chk(acks == 0 && en_cnt == e0, "R10 idle strobe", acks + en_cnt - e0, 0);

    // R12: unsplit word write then byte readback
    do_req(1'b1, 2'd1, 24'h000300, 20'h0, 1'b1, 16'hC3D4, rd, lat);
    chk(lat == 2, "R12 write latency", lat, 2);
    do_req(1'b0, 2'd0, 24'h000300, 20'h0, 1'b1, 16'h0, rd, lat);
    chk(rd == 16'h00D4, "R12 low byte", rd, 16'h00D4);
    do_req(1'b0, 2'd0, 24'h000301, 20'h0, 1'b1, 16'h0, rd, lat);
    chk(rd == 16'h00C3, "R12 high byte", rd, 16'h00C3);

    // R2: byte write touches one byte only
    do_req(1'b0, 2'd1, 24'h000400, 20'h0, 1'b1, 16'h77A5, rd, lat);
    do_req(1'b1, 2'd0, 24'h000400, 20'h0, 1'b1, 16'h0, rd, lat);
    exp = {pat(32'h401), 8'hA5};
    chk(rd == exp, "R2 byte write", rd, exp);

    // R8: split write at physical end
    e0 = en_cnt;
    do_req(1'b1, 2'd1, 24'h0FFFFF, 20'h0, 1'b0, 16'h1111, rd, lat);
    chk(lat == 1, "R8 latency", lat, 1);
    chk(en_cnt == e0, "R8 no memory cycle", en_cnt - e0, 0);

    // R11: refused while pending
    @(negedge clk);
    req = 1'b1; req_word = 1'b1; req_kind = 2'd0; req_addr = 24'h000300;
    watch(5, acks, ens);
    req = 1'b0;
    chk(acks == 0 && ens == 0, "R11 refused", acks + ens, 0);

    // R9: write-back stores both bytes
    do_wb(16'hBEEF, lat);
    chk(lat == 3, "R9 latency", lat, 3);
    do_req(1'b0, 2'd0, 24'h0FFFFF, 20'h0, 1'b0, 16'h0, rd, lat);
    chk(rd == 16'h00EF, "R9 low byte", rd, 16'h00EF);
    do_req(1'b0, 2'd0, 24'h000000, 20'h0, 1'b0, 16'h0, rd, lat);
    chk(rd == 16'h00BE, "R9 wrapped byte", rd, 16'h00BE);
    do_req(1'b1, 2'd0, 24'h0FFFFF, 20'h0, 1'b0, 16'h0, rd, lat);
    chk(rd == 16'hBEEF && lat == 3, "R6 split read after wb", rd, 16'hBEEF);

    // R7: split RMW at segment end
    exp = {rd8(32'h50000), rd8(32'h5FFFF)};
    do_req(1'b1, 2'd2, 24'h05FFFF, 20'h50000, 1'b1, 16'h9999, rd, lat);
    chk(rd == exp, "R7 seed", rd, exp);
    chk(lat == 3, "R7 latency", lat, 3);
    chk(rd8(32'h5FFFF) == exp[7:0] && rd8(32'h50000) == exp[15:8],
        "R7 memory untouched", {rd8(32'h50000), rd8(32'h5FFFF)}, exp);
    @(negedge clk);
    req = 1'b1; req_word = 1'b0; req_kind = 2'd0; req_addr = 24'h000300;
    watch(4, acks, ens);
    req = 1'b0;
    chk(acks == 0 && ens == 0, "R11 refused after RMW", acks + ens, 0);
    do_wb(16'h1234, lat);
    chk(lat == 3, "R9 RMW wb latency", lat, 3);
    do_req(1'b1, 2'd0, 24'h05FFFF, 20'h50000, 1'b1, 16'h0, rd, lat);
    chk(rd == 16'h1234, "R9 RMW result", rd, 16'h1234);

    // R12: unsplit RMW leaves nothing pending
    exp = {rd8(32'h601), rd8(32'h600)};
    do_req(1'b1, 2'd2, 24'h000600, 20'h0, 1'b1, 16'h0, rd, lat);
    chk(rd == exp && lat == 2, "R12 unsplit RMW", rd, exp);
    do_req(1'b0, 2'd0, 24'h000300, 20'h0, 1'b1, 16'h0, rd, lat);
    chk(lat == 2 && rd == 16'h00D4, "R12 next request accepted", lat, 2);
    e0 = en_cnt;
    do_wb(16'hAAAA, lat);
    chk(lat == 99 && en_cnt == e0, "R10 strobe after unsplit RMW", lat, 99);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule